// File: doc/BRIEF.md
# Edge-Latched Hold/Restart Counter

This block is a synchronous up-counter. On every clock it adds a fixed step to its count, unless it is frozen or restarting. Two control inputs steer it. Each is read only for its edges, never for its level. Both edge detectors live inside the block and compare each input with its value on the previous clock.

A rising edge on the hold input sets an internal hold latch. A falling edge on the hold input clears that latch. A rising edge on the restart input zeroes the count and also clears the latch, whatever level the hold input has at that moment. Restart therefore overrides a hold that is still asserted. Once restarted, the counter keeps counting while the hold input stays high, and it freezes again only on a fresh rising edge of the hold input.

Typical use is to accumulate a running total, such as elapsed cycles. An external condition pauses the total, and a separate event starts a new total even when the pause condition is still present. The held flag output reports the latch state.

Top module: `hold_restart_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, the held flag and both previous-input registers are cleared to zero. A hold input that is high on the first clock after reset is therefore seen as a rising edge.
- R2: At each clock edge where the held flag is low and no restart rising edge is present, the count grows by STEP (bench instance: STEP = 3).
- R3: A hold rising edge (hold low on the previous sampled clock, high now) sets the held flag at that edge. The count still advances at that same edge and stays unchanged at every following edge while the flag is set.
- R4: A hold falling edge (high on the previous sampled clock, low now) clears the held flag. The count does not change at that edge and advances again from the next edge.
- R5: A restart rising edge sets the count to 0 at that edge and clears the held flag, whatever level the hold input has.
- R6: After a restart that clears an active hold, the count advances from the next edge even though the hold input stays high. Only a new hold rising edge sets the flag again.
- R7: When a hold rising edge and a restart rising edge fall on the same clock, the restart wins: the count becomes 0 and the held flag is cleared.
- R8: A restart input that stays high, or that falls, has no effect after its rising edge. Counting proceeds normally.
- R9: The count is WIDTH bits wide and wraps modulo 2^WIDTH (bench instance: WIDTH = 8, so the count wraps from values near 255 back past 0).
- R10: The `held_o` output equals the hold latch state at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_i | input | 1 | Hold control; its rising edge freezes and its falling edge releases |
| restart_i | input | 1 | Restart control; its rising edge zeroes the count and cancels a hold |
| count_o | output | WIDTH | Current count value |
| held_o | output | 1 | Hold latch state |

## Verification
The hardest situation to reach is a restart rising edge that arrives while the hold input is still high and the latch is set. The count must then resume while hold stays high and must not freeze again until hold drops and rises anew. The stimulus gets there in steps. It first raises hold and keeps it high long enough to confirm the freeze. It then pulses restart and holds restart high across several cycles, which also shows that the restart level is ignored. Only after that does it release and re-raise hold. A separate sequence drives hold and restart high on the same clock, and a long free run with a small count width exercises the wrap.

// File: rtl/hrc_pkg.sv
// Package: hrc_pkg
// Shared types for the hold/restart counter.
// Assumes: nothing beyond standard SystemVerilog.
package hrc_pkg;

    // Edge pulses of one control input for the current clock
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    // Index of each control input inside the detector array
    localparam int unsigned CTRL_HOLD    = 0;
    localparam int unsigned CTRL_RESTART = 1;
    localparam int unsigned CTRL_COUNT   = 2;

endpackage

// File: rtl/hrc_edge_detect.sv
// Module: hrc_edge_detect
// Registers one control input and reports rising and falling edges by
// comparing the current value with the value sampled on the previous clock.
// Assumes: the input is already synchronous to clk.
module hrc_edge_detect
    import hrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_i,
    output edge_pair_t edge_o
);

    logic prev_q;

    // Capture the previous value; reset makes a high input look like a rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sig_i;
        end
    end

    // Form the edge pulses from the current and previous values
    always_comb begin
        edge_o.rise = sig_i & ~prev_q;
        edge_o.fall = ~sig_i & prev_q;
    end

endmodule

// File: rtl/hrc_hold_latch.sv
// Module: hrc_hold_latch
// Set/clear latch for the hold state. A cancel request beats a set request,
// and a set request beats a clear request.
// Assumes: set_i and clr_i are single-cycle edge pulses from one input.
module hrc_hold_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic cancel_i,
    output logic held_o
);

    logic held_q;
    logic held_d;

    // Next latch state with cancel > set > clear priority
    always_comb begin
        held_d = held_q;
        if (cancel_i) begin
            held_d = 1'b0;
        end else if (set_i) begin
            held_d = 1'b1;
        end else if (clr_i) begin
            held_d = 1'b0;
        end
    end

    // Latch state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else begin
            held_q <= held_d;
        end
    end

    assign held_o = held_q;

    // R5
    hold_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_i |=> !held_o);

    // R3
    hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !cancel_i) |=> held_o);

    // R4
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i && !cancel_i) |=> !held_o);

endmodule

// File: rtl/hrc_accum.sv
// Module: hrc_accum
// Count register. The step added each clock is STEP, or zero while frozen,
// and a zero request clears the register and suppresses the step.
// Assumes: zero_i is a single-cycle pulse; the count wraps modulo 2^WIDTH.
module hrc_accum #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned STEP  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_i,
    input  logic             freeze_i,
    output logic [WIDTH-1:0] count_o
);

    localparam logic [WIDTH-1:0] STEP_W = WIDTH'(STEP);

    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] incr;
    logic [WIDTH-1:0] base;

    // Pick the increment: zero when frozen or restarting, else the step
    always_comb begin
        incr = (freeze_i || zero_i) ? '0 : STEP_W;
        base = zero_i ? '0 : count_q;
    end

    // Count register, wraps naturally at the width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= base + incr;
        end
    end

    assign count_o = count_q;

    // R3
    frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !zero_i) |=> $stable(count_o));

endmodule

// File: rtl/hold_restart_counter.sv
// Module: hold_restart_counter
// Up-counter with an edge-driven hold latch and an edge-driven restart.
// Restart zeroes the count and cancels any hold, even while hold stays high.
// Assumes: hold_i and restart_i are synchronous to clk; reset is synchronous.
module hold_restart_counter
    import hrc_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned STEP  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             restart_i,
    output logic [WIDTH-1:0] count_o,
    output logic             held_o
);

    localparam logic [WIDTH-1:0] STEP_W = WIDTH'(STEP);

    logic [CTRL_COUNT-1:0] ctrl;
    edge_pair_t            edges [CTRL_COUNT];
    logic                  held;

    assign ctrl[CTRL_HOLD]    = hold_i;
    assign ctrl[CTRL_RESTART] = restart_i;

    // One edge detector per control input
    for (genvar g = 0; g < CTRL_COUNT; g++) begin : g_edge
        hrc_edge_detect u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_i  (ctrl[g]),
            .edge_o (edges[g])
        );
    end

    hrc_hold_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (edges[CTRL_HOLD].rise),
        .clr_i    (edges[CTRL_HOLD].fall),
        .cancel_i (edges[CTRL_RESTART].rise),
        .held_o   (held)
    );

    hrc_accum #(
        .WIDTH (WIDTH),
        .STEP  (STEP)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_i   (edges[CTRL_RESTART].rise),
        .freeze_i (held),
        .count_o  (count_o)
    );

    assign held_o = held;

    // R5
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edges[CTRL_RESTART].rise |=> (count_o == '0));

    // R2
    free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_o && !edges[CTRL_RESTART].rise) |=>
            (count_o == $past(count_o) + STEP_W));

    // R7
    tie_restart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edges[CTRL_HOLD].rise && edges[CTRL_RESTART].rise) |=>
            (!held_o && count_o == '0));

    // R8
    restart_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edges[CTRL_RESTART].fall && !held_o) |=>
            (count_o == $past(count_o) + STEP_W));

    // R6
    level_no_refreeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_o && !edges[CTRL_HOLD].rise) |=> !held_o);

endmodule

// File: tb/test_hold_restart_counter.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock.
module test_hold_restart_counter;

    localparam int unsigned WIDTH = 8;
    localparam int unsigned STEP  = 3;
    localparam int unsigned MASK  = (1 << WIDTH) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hold_i = 1'b0;
    logic             restart_i = 1'b0;
    logic [WIDTH-1:0] count_o;
    logic             held_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state
    int m_cnt  = 0;
    bit m_held = 1'b0;
    bit m_ph   = 1'b0;
    bit m_pr   = 1'b0;

    always #2 clk = ~clk;

    hold_restart_counter #(.WIDTH(WIDTH), .STEP(STEP)) i_hold_restart_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (hold_i),
        .restart_i (restart_i),
        .count_o   (count_o),
        .held_o    (held_o)
    );

    task automatic check_val(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at negedge
    task automatic step(input bit rn, input bit h, input bit r, input string tag);
        bit rr;
        bit rh;
        bit fh;
        rst_n     = rn;
        hold_i    = h;
        restart_i = r;
        @(posedge clk);
        if (!rn) begin
            m_cnt = 0; m_held = 0; m_ph = 0; m_pr = 0;
        end else begin
            rr = r && !m_pr;
            rh = h && !m_ph;
            fh = !h && m_ph;
            if (rr)          m_cnt = 0;
            else if (!m_held) m_cnt = (m_cnt + STEP) & MASK;
            if (rr)      m_held = 0;
            else if (rh) m_held = 1;
            else if (fh) m_held = 0;
            m_ph = h;
            m_pr = r;
        end
        @(negedge clk);
        check_val(tag, int'(count_o), m_cnt, "count");
        check_val(tag, int'(held_o), int'(m_held), "held");
    endtask

    initial begin
        int snap;
        @(negedge clk);
        // R1: reset with hold high
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, "R1");
        check_val("R1", int'(count_o), 0, "count in reset");
        check_val("R1", int'(held_o), 0, "held in reset");
        // R3: hold high after reset is a rising edge
        step(1'b1, 1'b1, 1'b0, "R3");
        check_val("R3", int'(count_o), STEP, "count at hold edge");
        check_val("R10", int'(held_o), 1, "held after hold edge");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, "R3");
        check_val("R3", int'(count_o), STEP, "frozen count");
        // R4: hold falls
        step(1'b1, 1'b0, 1'b0, "R4");
        check_val("R4", int'(count_o), STEP, "count at release edge");
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, "R2");
        check_val("R2", int'(count_o), 11 * STEP, "free count");
        // R5 and R6: hold active, restart while hold high
        step(1'b1, 1'b1, 1'b0, "R3");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, "R3");
        step(1'b1, 1'b1, 1'b1, "R5");
        check_val("R5", int'(count_o), 0, "count after restart");
        check_val("R5", int'(held_o), 0, "held after restart");
        // R8: restart kept high, R6: hold kept high
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, "R8");
        check_val("R6", int'(count_o), 5 * STEP, "counting with hold high");
        step(1'b1, 1'b1, 1'b0, "R8");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, "R6");
        check_val("R6", int'(held_o), 0, "no refreeze");
        // R6: only a new hold edge refreezes
        step(1'b1, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b0, "R6");
        snap = int'(count_o);
        step(1'b1, 1'b1, 1'b0, "R6");
        check_val("R6", int'(count_o), snap, "refrozen by new edge");
        step(1'b1, 1'b0, 1'b0, "R4");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R2");
        // R7: simultaneous edges
        step(1'b1, 1'b1, 1'b1, "R7");
        check_val("R7", int'(count_o), 0, "count on tie");
        check_val("R7", int'(held_o), 0, "held on tie");
        step(1'b1, 1'b1, 1'b0, "R7");
        check_val("R7", int'(count_o), STEP, "count after tie");
        step(1'b1, 1'b0, 1'b0, "R2");
        // R9: long run wraps the count
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 1'b0, "R9");
        // R1: reset in mid-run
        step(1'b0, 1'b0, 1'b0, "R1");
        check_val("R1", int'(count_o), 0, "count after late reset");
        step(1'b1, 1'b0, 1'b0, "R2");
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule